// File: doc/BRIEF.md
# Parallel-to-Scan Test Bus Bridge

This block lets a processor drive an IEEE 1149.1 scan chain through a small synchronous register interface. The host stages a data byte and then writes a TMS pattern byte. The pair is shifted out least significant bit first: the data goes on TDO and the pattern goes on whichever of two TMS outputs is selected. Bits that come back on TDI are packed into bytes that the host reads. A 32-bit count sets how many TCK cycles an operation runs.

TCK is produced from the system clock. It is held low whenever the next bit has not been supplied, or whenever a finished receive byte would overwrite one the host has not read yet. Because TMS comes straight from host words, the block has no built-in idea of the target's state machine. Two optional modes serve self-test:

- a 16-bit multiple-input signature register folds the returning TDI stream into a signature;
- a 16-bit maximal-length pattern generator replaces host data on TDO.

Top module: `scan_bridge`

Register map (8-bit bus, 4-bit address):

| Address | Access | Contents |
|---|---|---|
| 0x0 | read/write | control: bit0 selects the chain (0 = `tms_a`, 1 = `tms_b`), bit1 compaction mode, bit2 generation mode; writing 1 to bit3 starts an operation |
| 0x1 | read | status: bit0 transmit buffer empty, bit1 receive byte waiting, bit2 count is zero, bit3 operation finished |
| 0x2 | read/write | half period of TCK in system clocks |
| 0x3 | write | staged data byte |
| 0x4 | write | pattern byte; also commits the pair to the transmit buffer |
| 0x5 | read | received byte; reading it frees the receive buffer |
| 0x8..0xB | read/write | count, least significant byte at 0x8 |
| 0xC, 0xD | read | signature, low byte then high byte |
| 0xE, 0xF | read | pattern generator, low byte then high byte |

## Requirements
- R1: After reset, the outputs and registers take these values: `tck` = 0, `tdo` = 0, `tms_a` = 1, `tms_b` = 1, status = 0x05, signature = 0xFFFF, generator = 0xFFFF.
- R2: Each committed data byte appears on `tdo` least significant bit first, one bit per TCK cycle. Each bit is set up before the rising TCK edge and holds across it.
- R3: The committed pattern byte drives the selected TMS output (control bit0) least significant bit first, in step with `tdo`. The unselected TMS output keeps its last value.
- R4: TDI is sampled on each rising TCK edge. The first sampled bit lands in bit0 of a received byte, which is read at 0x5. Reading 0x5 clears status bit1, and a byte held back behind it then moves into the buffer.
- R5: If bits are still due and no committed pair remains (status bit0 = 1), TCK stays low. It resumes once a pair is written, and no bit is skipped or repeated.
- R6: Outside compaction mode, TCK stays low after a receive byte completes while the previous byte is unread. It resumes once 0x5 is read, and no returning bit is lost.
- R7: An operation produces exactly as many rising TCK edges as the count held when it started. The count drops by one on each rising edge and can be read back, and status bits 2 and 3 are set when it reaches zero.
- R8: With half period H (0x2), TCK is high for H system clocks. Successive rising edges are 2H+1 system clocks apart when nothing stalls. A value of 0 behaves as 1.
- R9: In compaction mode (control bit1), each TDI bit b updates the signature S to (S<<1) ^ (0x1021 if S[15]^b). The receive buffer is left alone, so status bit1 stays 0 and no overflow stall occurs.
- R10: In generation mode (control bit2), `tdo` carries bit0 of the generator G for each bit. G then steps to {G[0]^G[2]^G[3]^G[5], G[15:1]}. Host data has no effect on `tdo`, while TMS still follows the pattern byte.
- R11: A start with a count of zero sets status bit3 at once and produces no TCK edge. Writes to 0x8..0xB while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at 0x5) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tck | output | 1 | Scan test clock |
| tdo | output | 1 | Serial data toward the chain |
| tdi | input | 1 | Serial data returning from the chain |
| tms_a | output | 1 | Mode select for chain A |
| tms_b | output | 1 | Mode select for chain B |

## Verification
The hardest state to reach is an overflow stall. It only arises once a second received byte has completed on top of an unread first one, and it must happen while bits are still owed. That needs a 24-cycle operation fed three pairs, with the host deliberately leaving 0x5 unread. The bench models the target chain at the TCK edges: it drives TDI on falling edges and records TDO and both TMS lines on rising edges. It then counts rising edges during a long idle wait to show the clock froze at exactly 16. The underflow stall is reached the same way, by committing only one pair for a 16-cycle operation.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOW, SQ_HIGH} tck_state_e;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h1;
  localparam logic [3:0] A_DIV  = 4'h2;
  localparam logic [3:0] A_TXD  = 4'h3;
  localparam logic [3:0] A_TMS  = 4'h4;
  localparam logic [3:0] A_RXD  = 4'h5;
  localparam logic [3:0] A_CNT  = 4'h8;
  localparam logic [3:0] A_MISR = 4'hC;
  localparam logic [3:0] A_LFSR = 4'hE;

  localparam int CB_SEL = 0;
  localparam int CB_CMP = 1;
  localparam int CB_GEN = 2;
  localparam int CB_GO  = 3;
endpackage

// File: rtl/scan_tck_seq.sv
`timescale 1ns/1ps
module scan_tck_seq import scan_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             can_go,
  input  logic [DIV_W-1:0] half,
  output logic             tck,
  output logic             issue,
  output logic             rise
);
  tck_state_e       state_q, state_d;
  logic [DIV_W-1:0] hc_q, hc_d;
  logic [DIV_W-1:0] half_eff;
  logic             tck_q;

  assign half_eff = (half == '0) ? DIV_W'(1) : half;

  always_comb begin
    state_d = state_q;
    hc_d    = hc_q;
    issue   = 1'b0;
    rise    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (run && can_go) begin
          issue   = 1'b1;
          state_d = SQ_LOW;
          hc_d    = half_eff - DIV_W'(1);
        end
      end
      SQ_LOW: begin
        if (hc_q == '0) begin
          rise    = 1'b1;
          state_d = SQ_HIGH;
          hc_d    = half_eff - DIV_W'(1);
        end else begin
          hc_d = hc_q - DIV_W'(1);
        end
      end
      SQ_HIGH: begin
        if (hc_q == '0) state_d = SQ_IDLE;
        else            hc_d    = hc_q - DIV_W'(1);
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      hc_q    <= '0;
      tck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hc_q    <= hc_d;
      tck_q   <= (state_d == SQ_HIGH);
    end
  end

  assign tck = tck_q;

  assert_rise_raises_tck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> tck);
  assert_issue_while_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !tck);
endmodule

// File: rtl/scan_sig.sv
`timescale 1ns/1ps
module scan_sig #(
  parameter int              SIG_W     = 16,
  parameter logic [SIG_W-1:0] MISR_POLY = 16'h1021,
  parameter logic [SIG_W-1:0] LFSR_TAPS = 16'h002D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             misr_en,
  input  logic             misr_bit,
  input  logic             lfsr_en,
  output logic [SIG_W-1:0] misr,
  output logic [SIG_W-1:0] lfsr,
  output logic             gen_bit
);
  logic [SIG_W-1:0] misr_q, misr_d, lfsr_q, lfsr_d;
  logic             mfb, lfb;

  always_comb begin
    mfb    = misr_q[SIG_W-1] ^ misr_bit;
    lfb    = ^(lfsr_q & LFSR_TAPS);
    misr_d = misr_q;
    lfsr_d = lfsr_q;
    if (misr_en) misr_d = {misr_q[SIG_W-2:0], 1'b0} ^ ({SIG_W{mfb}} & MISR_POLY);
    if (lfsr_en) lfsr_d = {lfb, lfsr_q[SIG_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misr_q <= '1;
      lfsr_q <= '1;
    end else begin
      misr_q <= misr_d;
      lfsr_q <= lfsr_d;
    end
  end

  assign misr    = misr_q;
  assign lfsr    = lfsr_q;
  assign gen_bit = lfsr_q[0];

  assert_gen_never_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  assert_sig_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !misr_en |=> $stable(misr_q));
endmodule

// File: rtl/scan_txrx.sv
`timescale 1ns/1ps
module scan_txrx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic         rise,
  input  logic         tdi,
  input  logic         chain_sel,
  input  logic         compact,
  input  logic         gen_mode,
  input  logic         gen_bit,
  input  logic         op_start,
  input  logic         stg_wr,
  input  logic         pair_wr,
  input  logic         rx_pop,
  input  logic [W-1:0] wdata,
  output logic         tdo,
  output logic         tms_a,
  output logic         tms_b,
  output logic         tx_full,
  output logic         rx_full,
  output logic [W-1:0] rx_data,
  output logic         can_go
);
  localparam int             CW   = $clog2(W + 1);
  localparam logic [CW-1:0]  FULL = CW'(W);

  logic [W-1:0]  stg_q, stg_d, bufd_q, bufd_d, buft_q, buft_d;
  logic [W-1:0]  txsh_q, txsh_d, tmssh_q, tmssh_d;
  logic [W-1:0]  rxsh_q, rxsh_d, rxbuf_q, rxbuf_d;
  logic [CW-1:0] txcnt_q, txcnt_d, rxcnt_q, rxcnt_d;
  logic          full_q, full_d, rxfull_q, rxfull_d;
  logic          tdo_q, tdo_d, ta_q, ta_d, tb_q, tb_d;
  logic          load;
  logic [W-1:0]  word_d, word_t;

  assign load   = issue && (txcnt_q == '0);
  assign word_d = load ? bufd_q : txsh_q;
  assign word_t = load ? buft_q : tmssh_q;
  assign can_go = ((txcnt_q != '0) || full_q) && (compact || (rxcnt_q != FULL));

  always_comb begin
    stg_d   = stg_q;   bufd_d  = bufd_q;  buft_d  = buft_q;  full_d  = full_q;
    txsh_d  = txsh_q;  tmssh_d = tmssh_q; txcnt_d = txcnt_q;
    tdo_d   = tdo_q;   ta_d    = ta_q;    tb_d    = tb_q;
    rxsh_d  = rxsh_q;  rxcnt_d = rxcnt_q; rxbuf_d = rxbuf_q; rxfull_d = rxfull_q;

    if (stg_wr) stg_d = wdata;
    if (load) full_d = 1'b0;
    if (pair_wr) begin
      bufd_d = stg_q;
      buft_d = wdata;
      full_d = 1'b1;
    end

    if (issue) begin
      tdo_d = gen_mode ? gen_bit : word_d[0];
      if (chain_sel) tb_d = word_t[0];
      else           ta_d = word_t[0];
      txsh_d  = word_d >> 1;
      tmssh_d = word_t >> 1;
      txcnt_d = (load ? FULL : txcnt_q) - CW'(1);
    end

    if (rise && !compact) begin
      rxsh_d  = {tdi, rxsh_q[W-1:1]};
      rxcnt_d = rxcnt_q + CW'(1);
    end else if ((rxcnt_q == FULL) && !rxfull_q) begin
      rxbuf_d  = rxsh_q;
      rxfull_d = 1'b1;
      rxcnt_d  = '0;
    end
    if (rx_pop && rxfull_q) rxfull_d = 1'b0;

    if (op_start) begin
      txcnt_d = '0;
      rxcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0; bufd_q <= '0; buft_q <= '0; full_q <= 1'b0;
      txsh_q <= '0; tmssh_q <= '0; txcnt_q <= '0;
      tdo_q <= 1'b0; ta_q <= 1'b1; tb_q <= 1'b1;
      rxsh_q <= '0; rxcnt_q <= '0; rxbuf_q <= '0; rxfull_q <= 1'b0;
    end else begin
      stg_q <= stg_d; bufd_q <= bufd_d; buft_q <= buft_d; full_q <= full_d;
      txsh_q <= txsh_d; tmssh_q <= tmssh_d; txcnt_q <= txcnt_d;
      tdo_q <= tdo_d; ta_q <= ta_d; tb_q <= tb_d;
      rxsh_q <= rxsh_d; rxcnt_q <= rxcnt_d; rxbuf_q <= rxbuf_d; rxfull_q <= rxfull_d;
    end
  end

  assign tdo     = tdo_q;
  assign tms_a   = ta_q;
  assign tms_b   = tb_q;
  assign tx_full = full_q;
  assign rx_full = rxfull_q;
  assign rx_data = rxbuf_q;

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((txcnt_q != '0) || full_q));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !compact) |-> (rxcnt_q != FULL));
  assert_tms_b_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && chain_sel) |=> $stable(tb_q));
  assert_tms_a_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && !chain_sel) |=> $stable(ta_q));
endmodule

// File: rtl/scan_bridge.sv
`timescale 1ns/1ps
module scan_bridge import scan_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8,
  parameter int SIG_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tck,
  output logic       tdo,
  input  logic       tdi,
  output logic       tms_a,
  output logic       tms_b
);
  localparam int CNT_B = CNT_W / BUS_W;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [2:0]       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d, done_q, done_d;
  logic [CNT_B-1:0] cnt_we;
  logic             go_req, go_ok;
  logic             issue, rise, can_go;
  logic             tx_full, rx_full, gen_bit;
  logic [BUS_W-1:0] rx_data;
  logic [SIG_W-1:0] misr, lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign go_req = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CB_GO];
  assign go_ok  = go_req && !active_q;

  for (genvar b = 0; b < CNT_B; b++) begin : g_cnt_we
    assign cnt_we[b] = bus_wr && !active_q && (bus_addr == (A_CNT + 4'(b)));
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    div_d    = div_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    done_d   = done_q;
    if (bus_wr && bus_addr == A_CTRL) ctrl_d = bus_wdata[2:0];
    if (bus_wr && bus_addr == A_DIV)  div_d  = bus_wdata[DIV_W-1:0];
    for (int b = 0; b < CNT_B; b++)
      if (cnt_we[b]) cnt_d[b*BUS_W +: BUS_W] = bus_wdata;
    if (go_ok) begin
      if (cnt_q == '0) done_d = 1'b1;
      else begin
        active_d = 1'b1;
        done_d   = 1'b0;
      end
    end
    if (rise) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q   <= '0;
      div_q    <= DIV_W'(1);
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {5'b0, ctrl_q};
      A_STAT: bus_rdata = {4'b0, done_q, (cnt_q == '0), rx_full, !tx_full};
      A_DIV:  bus_rdata = BUS_W'(div_q);
      A_RXD:  bus_rdata = rx_data;
      A_MISR:        bus_rdata = misr[7:0];
      A_MISR + 4'd1: bus_rdata = misr[15:8];
      A_LFSR:        bus_rdata = lfsr[7:0];
      A_LFSR + 4'd1: bus_rdata = lfsr[15:8];
      default: begin
        for (int b = 0; b < CNT_B; b++)
          if (bus_addr == (A_CNT + 4'(b))) bus_rdata = cnt_q[b*BUS_W +: BUS_W];
      end
    endcase
  end

  scan_tck_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .run(active_q), .can_go(can_go),
    .half(div_q), .tck(tck), .issue(issue), .rise(rise)
  );

  scan_txrx #(.W(BUS_W)) u_txrx (
    .clk(clk), .rst_n(rst_i_n), .issue(issue), .rise(rise), .tdi(tdi),
    .chain_sel(ctrl_q[CB_SEL]), .compact(ctrl_q[CB_CMP]), .gen_mode(ctrl_q[CB_GEN]),
    .gen_bit(gen_bit), .op_start(go_ok),
    .stg_wr(bus_wr && bus_addr == A_TXD), .pair_wr(bus_wr && bus_addr == A_TMS),
    .rx_pop(bus_rd && bus_addr == A_RXD), .wdata(bus_wdata),
    .tdo(tdo), .tms_a(tms_a), .tms_b(tms_b), .tx_full(tx_full),
    .rx_full(rx_full), .rx_data(rx_data), .can_go(can_go)
  );

  scan_sig #(.SIG_W(SIG_W)) u_sig (
    .clk(clk), .rst_n(rst_i_n),
    .misr_en(rise && ctrl_q[CB_CMP]), .misr_bit(tdi),
    .lfsr_en(issue && ctrl_q[CB_GEN]),
    .misr(misr), .lfsr(lfsr), .gen_bit(gen_bit)
  );

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rise |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_no_edge_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !active_q |-> !issue);
  assert_zero_start_done_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (go_ok && cnt_q == '0) |=> (done_q && !active_q));
endmodule

// File: tb/sim_scan_bridge.sv
`timescale 1ns/1ps
module sim_scan_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tck, tdo, tms_a, tms_b;
  logic       tdi = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic src [0:63];
  int   src_idx = 0;
  logic cap_tdo [0:63];
  logic cap_ta  [0:63];
  logic cap_tb  [0:63];
  int   rise_cnt = 0;
  time  t_prev = 0, per = 0, hi = 0;

  scan_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tck(tck), .tdo(tdo), .tdi(tdi), .tms_a(tms_a), .tms_b(tms_b)
  );

  always #5 clk = ~clk;

  // target-chain model: capture on rising TCK, present next TDI bit on falling TCK
  always @(posedge tck) begin
    if (rise_cnt < 64) begin
      cap_tdo[rise_cnt] = tdo;
      cap_ta[rise_cnt]  = tms_a;
      cap_tb[rise_cnt]  = tms_b;
    end
    rise_cnt++;
    if (t_prev != 0) per = $time - t_prev;
    t_prev = $time;
  end
  always @(negedge tck) begin
    hi = $time - t_prev;
    if (src_idx < 63) src_idx++;
    tdi = src[src_idx];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_count(input logic [31:0] c);
    for (int b = 0; b < 4; b++) wr(4'(8 + b), c[b*8 +: 8]);
  endtask

  task automatic load_src(input logic [7:0] w0, input logic [7:0] w1, input logic [7:0] w2);
    for (int i = 0; i < 8; i++) begin
      src[i] = w0[i]; src[8+i] = w1[i]; src[16+i] = w2[i];
    end
    for (int i = 24; i < 64; i++) src[i] = 1'b0;
    src_idx = 0; tdi = src[0]; rise_cnt = 0; t_prev = 0;
  endtask

  task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val);
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h1, s);
      if ((s & mask) == val) break;
    end
  endtask

  task automatic feed(input logic [7:0] d, input logic [7:0] t);
    wait_stat(8'h01, 8'h01);
    wr(4'h3, d); wr(4'h4, t);
  endtask

  task automatic wait_done;
    wait_stat(8'h08, 8'h08);
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [7:0] cap_word(input int base, input int which);
    logic [7:0] w;
    for (int i = 0; i < 8; i++)
      w[i] = (which == 0) ? cap_tdo[base+i] : (which == 1) ? cap_ta[base+i] : cap_tb[base+i];
    return w;
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 tck", 32'(tck), 0);
    chk("R1 tdo", 32'(tdo), 0);
    chk("R1 tms_a", 32'(tms_a), 1);
    chk("R1 tms_b", 32'(tms_b), 1);
    rd(4'h1, v); chk("R1 status", 32'(v), 32'h05);
    rd(4'hC, v); chk("R1 sig lo", 32'(v), 32'hFF);
    rd(4'hD, v); chk("R1 sig hi", 32'(v), 32'hFF);
    rd(4'hE, v); chk("R1 gen lo", 32'(v), 32'hFF);
    rd(4'hF, v); chk("R1 gen hi", 32'(v), 32'hFF);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(4'h2, 8'd2); wr(4'h0, 8'h00);
    load_src(8'h96, 8'h2D, 8'h00);
    feed(8'hA5, 8'h3C);
    set_count(32'd16);
    wr(4'h0, 8'h08);
    feed(8'h5A, 8'h43);
    wait_done;
    chk("R2 tdo word0", 32'(cap_word(0, 0)), 32'hA5);
    chk("R2 tdo word1", 32'(cap_word(8, 0)), 32'h5A);
    chk("R3 tms_a word0", 32'(cap_word(0, 1)), 32'h3C);
    chk("R3 tms_a word1", 32'(cap_word(8, 1)), 32'h43);
    chk("R3 tms_b held", 32'(cap_word(0, 2)) & 32'(cap_word(8, 2)), 32'hFF);
    chk("R7 edge count", 32'(rise_cnt), 16);
    rd(4'h1, v); chk("R7 status zero+done", 32'(v & 8'h0C), 32'h0C);
    rd(4'h8, v); chk("R7 count readback", 32'(v), 0);
    rd(4'h5, v); chk("R4 rx word0", 32'(v), 32'h96);
    rd(4'h1, v); chk("R4 rx refilled", 32'(v & 8'h02), 32'h02);
    rd(4'h5, v); chk("R4 rx word1", 32'(v), 32'h2D);
    rd(4'h1, v); chk("R4 rx cleared", 32'(v & 8'h02), 0);
  endtask

  task automatic t_chain_b;
    logic [7:0] v;
    wr(4'h0, 8'h01);
    load_src(8'h00, 8'h00, 8'h00);
    feed(8'h00, 8'h8E);
    set_count(32'd8);
    wr(4'h0, 8'h09);
    wait_done;
    chk("R3 tms_b word", 32'(cap_word(0, 2)), 32'h8E);
    chk("R3 tms_a held low", 32'(cap_word(0, 1)), 32'h00);
    rd(4'h5, v);
  endtask

  task automatic t_underflow;
    logic [7:0] v;
    wr(4'h2, 8'd1); wr(4'h0, 8'h00);
    load_src(8'h00, 8'h00, 8'h00);
    feed(8'h11, 8'h00);
    set_count(32'd16);
    wr(4'h0, 8'h08);
    repeat (200) @(negedge clk);
    chk("R5 edges before stall", 32'(rise_cnt), 8);
    chk("R5 tck low in stall", 32'(tck), 0);
    rd(4'h1, v); chk("R5 status empty not done", 32'(v & 8'h09), 32'h01);
    rd(4'h8, v); chk("R7 count mid-op", 32'(v), 8);
    feed(8'h22, 8'h00);
    wait_done;
    chk("R5 tdo word0", 32'(cap_word(0, 0)), 32'h11);
    chk("R5 tdo word1", 32'(cap_word(8, 0)), 32'h22);
    rd(4'h5, v); rd(4'h5, v);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    load_src(8'hF0, 8'h0F, 8'h55);
    feed(8'h00, 8'h00);
    set_count(32'd24);
    wr(4'h0, 8'h08);
    feed(8'h00, 8'h00);
    feed(8'h00, 8'h00);
    repeat (200) @(negedge clk);
    chk("R6 edges before stall", 32'(rise_cnt), 16);
    chk("R6 tck low in stall", 32'(tck), 0);
    rd(4'h5, v); chk("R6 rx word0", 32'(v), 32'hF0);
    wait_done;
    chk("R6 total edges", 32'(rise_cnt), 24);
    rd(4'h5, v); chk("R6 rx word1", 32'(v), 32'h0F);
    rd(4'h5, v); chk("R6 rx word2", 32'(v), 32'h55);
  endtask

  task automatic t_timing;
    wr(4'h2, 8'd3);
    load_src(8'h00, 8'h00, 8'h00);
    feed(8'h0F, 8'h00);
    set_count(32'd4);
    wr(4'h0, 8'h08);
    wait_done;
    chk("R8 period H=3", 32'(per), 70);
    chk("R8 high H=3", 32'(hi), 30);
    wr(4'h2, 8'd0);
    load_src(8'h00, 8'h00, 8'h00);
    feed(8'h0F, 8'h00);
    set_count(32'd4);
    wr(4'h0, 8'h08);
    wait_done;
    chk("R8 period H=0", 32'(per), 30);
    chk("R8 high H=0", 32'(hi), 10);
  endtask

  task automatic t_compact;
    logic [7:0]  v, lo;
    logic [15:0] m;
    wr(4'h2, 8'd1); wr(4'h0, 8'h02);
    load_src(8'h3A, 8'hC5, 8'h00);
    feed(8'h00, 8'h00);
    set_count(32'd16);
    wr(4'h0, 8'h0A);
    feed(8'h00, 8'h00);
    wait_done;
    m = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      logic fb;
      fb = m[15] ^ src[i];
      m = {m[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    chk("R9 edge count", 32'(rise_cnt), 16);
    rd(4'h1, v); chk("R9 rx untouched", 32'(v & 8'h02), 0);
    rd(4'hC, lo); rd(4'hD, v);
    chk("R9 signature", {16'h0, v, lo}, {16'h0, m});
  endtask

  task automatic t_generate;
    logic [7:0]  v, lo, e0, e1;
    logic [15:0] g;
    wr(4'h0, 8'h04);
    load_src(8'h00, 8'h00, 8'h00);
    feed(8'hFF, 8'hA5);
    set_count(32'd16);
    wr(4'h0, 8'h0C);
    feed(8'hFF, 8'h5A);
    wait_done;
    g = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      if (i < 8) e0[i] = g[0]; else e1[i-8] = g[0];
      g = {g[0] ^ g[2] ^ g[3] ^ g[5], g[15:1]};
    end
    chk("R10 tdo word0", 32'(cap_word(0, 0)), 32'(e0));
    chk("R10 tdo word1", 32'(cap_word(8, 0)), 32'(e1));
    chk("R10 tms follows", 32'(cap_word(0, 1)), 32'hA5);
    rd(4'hE, lo); rd(4'hF, v);
    chk("R10 generator state", {16'h0, v, lo}, {16'h0, g});
    rd(4'h5, v); rd(4'h5, v);
  endtask

  task automatic t_zero;
    logic [7:0] v;
    wr(4'h0, 8'h00);
    load_src(8'h00, 8'h00, 8'h00);
    set_count(32'd0);
    wr(4'h0, 8'h08);
    rd(4'h1, v); chk("R11 zero-count done", 32'(v & 8'h0C), 32'h0C);
    repeat (50) @(negedge clk);
    chk("R11 no edges", 32'(rise_cnt), 0);
    set_count(32'd8);
    wr(4'h0, 8'h08);
    wr(4'h8, 8'h55);
    rd(4'h8, v); chk("R11 count write ignored", 32'(v), 8);
    feed(8'h00, 8'h00);
    wait_done;
    chk("R11 edges after ignored write", 32'(rise_cnt), 8);
    rd(4'h5, v);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) src[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_chain_b;
    t_underflow;
    t_overflow;
    t_timing;
    t_compact;
    t_generate;
    t_zero;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule